// File: doc/BRIEF.md
# 1-Wire Slave Physical Layer

This block is the bit-level front end of a 1-Wire slave that sits on a shared open-drain data line. It watches the line through a synchronizer. It recognises a long low level as a bus reset and answers it with a presence pulse. It turns each master-initiated time slot into either a received bit or a transmitted bit. Whether a slot is a read or a write is up to the upper layer. If a transmit bit is offered (`tx_valid` high) when the slot's falling edge is seen, the slot is treated as a read slot and the offered bit is sent. Otherwise the slot is decoded as a write slot and the sampled level is handed up.

The line is never driven high. The block only asks for the line to be pulled low, through `dq_pull_low`, and an external resistor supplies the high level. All durations scale with `CLKS_PER_US`, which is the number of clock cycles in one microsecond. The `overdrive` input selects the short timing set, and it must only change while the bus is idle. Command decoding, addressing and storage belong to the layer above.

Timing in the requirements below counts rising clock edges from the clock cycle in which `dq_in` changes, with the default two synchronizer stages. With that default, the block first reacts to a line change on the third edge. T(x) means x × `CLKS_PER_US` cycles.

Top module: `owire_slave_phy`

## Requirements
- R1: While `rst_n` is low and right after it rises, `dq_pull_low`, `rx_valid`, `reset_seen` and `tx_ack` are all 0.
- R2: A low level lasting T(480) raises `reset_seen` for exactly one cycle, in the cycle after edge T(480)+2 counted from the fall. It fires once per low period. Any slot in progress is abandoned, and the pull-down is released on the next edge. Because the fall that starts a reset also looks like a slot start, a write-0 bit may be delivered before `reset_seen`.
- R3: After a reset, once the line is high again, `dq_pull_low` goes to 1 after edge P+3 counted from the rise, and it stays at 1 for exactly L cycles. At standard speed P = T(30) and L = T(120).
- R4: A falling edge seen while idle with `tx_valid` low starts a write slot. `rx_valid` is 1 for exactly one cycle, after edge S+4 counted from the fall. At standard speed S = T(30).
- R5: In a write slot, `rx_bit` is 1 if the synchronized line was high at the sample point, and 0 if it was low.
- R6: A falling edge seen while idle with `tx_valid` high starts a read slot. `tx_ack` is 1 for exactly one cycle, after edge 3. If `tx_bit` is 0, `dq_pull_low` is 1 from that edge for exactly H cycles and then 0. At standard speed H = T(30).
- R7: In a read slot with `tx_bit` = 1, `dq_pull_low` stays 0 and the line reads high. A read slot never produces `rx_valid`.
- R8: A slot started with `tx_valid` low never raises `tx_ack`.
- R9: With `overdrive` = 1, P = T(3), L = T(10), S = T(3) and H = T(3).
- R10: A falling edge that arrives while the presence sequence is running starts no slot. It produces no `rx_valid` and no `tx_ack`, and it leaves the presence timing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| overdrive | input | 1 | 1 selects the short (overdrive) timing set |
| dq_in | input | 1 | Raw level of the shared data line |
| dq_pull_low | output | 1 | 1 asks the open-drain driver to pull the line low |
| rx_valid | output | 1 | One-cycle strobe: a write-slot bit is available |
| rx_bit | output | 1 | Decoded write-slot bit, valid with `rx_valid` |
| reset_seen | output | 1 | One-cycle strobe: a bus reset was recognised |
| tx_valid | input | 1 | Upper layer offers a bit for the next slot |
| tx_bit | input | 1 | Bit to send in a read slot |
| tx_ack | output | 1 | One-cycle strobe: the offered bit was taken for a read slot |

## Verification
Every result has a fixed due cycle, counted in rising edges from the line change that causes it:
- the read-slot acknowledge is due on edge 3;
- the write bit is due on edge S+4;
- the reset strobe is due on edge T(480)+2;
- the presence pull-down starts on edge P+3 after the release and ends L cycles later.

The bench changes the line on falling clock edges and counts rising edges with the same step task that moves time. At each due cycle it checks the output both at the edge where it should appear and at the edge before, and both at the last cycle it should hold and at the one after. A strobe that comes early or late, or that lasts a cycle too long, is therefore caught. Outputs that must stay quiet are tallied by a monitor across whole slots.

// File: rtl/owire_pkg.sv
package owire_pkg;

   // Microsecond figures of the two speed sets
   localparam int unsigned STD_PRES_WAIT_US = 30;
   localparam int unsigned STD_PRES_LOW_US  = 120;
   localparam int unsigned STD_SAMPLE_US    = 30;
   localparam int unsigned STD_HOLD_US      = 30;
   localparam int unsigned OD_PRES_WAIT_US  = 3;
   localparam int unsigned OD_PRES_LOW_US   = 10;
   localparam int unsigned OD_SAMPLE_US     = 3;
   localparam int unsigned OD_HOLD_US       = 3;
   localparam int unsigned BUS_RESET_US     = 480;

   typedef enum logic [2:0] {
      PHY_IDLE,
      PHY_WRITE_SLOT,
      PHY_READ_SLOT,
      PHY_WAIT_HIGH,
      PHY_RESET_LOW,
      PHY_PRES_WAIT,
      PHY_PRES_LOW
   } phy_state_e;

endpackage

// File: rtl/owire_line_sync.sv
module owire_line_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_raw,
   output logic line_s,
   output logic fall
);

   logic [STAGES-1:0] chain;
   logic              line_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("owire_line_sync: STAGES must be 2 or more");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b1;
               else        chain[0] <= line_raw;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b1;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign line_s = chain[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_q <= 1'b1;
      else        line_q <= line_s;
   end

   assign fall = line_q & ~line_s;

endmodule

// File: rtl/owire_low_timer.sv
module owire_low_timer #(
   parameter int unsigned LIMIT = 960
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_s,
   output logic hit
);

   localparam int unsigned W = $clog2(LIMIT + 1);
   localparam logic [W-1:0] LIM      = W'(LIMIT);
   localparam logic [W-1:0] LIM_LAST = W'(LIMIT - 1);

   logic [W-1:0] low_cnt;

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("owire_low_timer: LIMIT must be 2 or more");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt <= '0;
         hit     <= 1'b0;
      end else begin
         hit <= 1'b0;
         if (line_s) begin
            low_cnt <= '0;
         end else begin
            if (low_cnt != LIM) low_cnt <= low_cnt + 1'b1;
            if (low_cnt == LIM_LAST) hit <= 1'b1;
         end
      end
   end

   // R2: reset strobe only after a low line, and only one cycle wide
   p_hit_after_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> $past(!line_s));
   p_hit_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> !hit);

endmodule

// File: rtl/owire_slot_fsm.sv
module owire_slot_fsm
   import owire_pkg::*;
#(
   parameter int unsigned CLKS_PER_US = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic overdrive,
   input  logic line_s,
   input  logic fall,
   input  logic rst_hit,
   input  logic tx_valid,
   input  logic tx_bit,
   output logic drive_low,
   output logic rx_valid,
   output logic rx_bit,
   output logic tx_ack
);

   localparam int unsigned CW = $clog2(STD_PRES_LOW_US * CLKS_PER_US + 1);
   localparam logic [CW-1:0] S_PDH  = CW'(STD_PRES_WAIT_US * CLKS_PER_US);
   localparam logic [CW-1:0] S_PDL  = CW'(STD_PRES_LOW_US  * CLKS_PER_US);
   localparam logic [CW-1:0] S_SAMP = CW'(STD_SAMPLE_US    * CLKS_PER_US);
   localparam logic [CW-1:0] S_HOLD = CW'(STD_HOLD_US      * CLKS_PER_US);
   localparam logic [CW-1:0] O_PDH  = CW'(OD_PRES_WAIT_US  * CLKS_PER_US);
   localparam logic [CW-1:0] O_PDL  = CW'(OD_PRES_LOW_US   * CLKS_PER_US);
   localparam logic [CW-1:0] O_SAMP = CW'(OD_SAMPLE_US     * CLKS_PER_US);
   localparam logic [CW-1:0] O_HOLD = CW'(OD_HOLD_US       * CLKS_PER_US);

   phy_state_e    state;
   logic [CW-1:0] cnt;
   logic          send_q;
   logic [CW-1:0] t_pdh, t_pdl, t_samp, t_hold;

   always_comb begin
      t_pdh  = overdrive ? O_PDH  : S_PDH;
      t_pdl  = overdrive ? O_PDL  : S_PDL;
      t_samp = overdrive ? O_SAMP : S_SAMP;
      t_hold = overdrive ? O_HOLD : S_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= PHY_IDLE;
         cnt      <= '0;
         send_q   <= 1'b1;
         rx_valid <= 1'b0;
         rx_bit   <= 1'b0;
         tx_ack   <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         tx_ack   <= 1'b0;
         if (rst_hit) begin
            state <= PHY_RESET_LOW;
            cnt   <= '0;
         end else begin
            case (state)
               PHY_IDLE: begin
                  if (fall) begin
                     cnt <= '0;
                     if (tx_valid) begin
                        state  <= PHY_READ_SLOT;
                        send_q <= tx_bit;
                        tx_ack <= 1'b1;
                     end else begin
                        state <= PHY_WRITE_SLOT;
                     end
                  end
               end
               PHY_WRITE_SLOT: begin
                  if (cnt >= t_samp) begin
                     rx_valid <= 1'b1;
                     rx_bit   <= line_s;
                     state    <= PHY_WAIT_HIGH;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               PHY_READ_SLOT: begin
                  if (cnt >= t_hold - 1'b1) state <= PHY_WAIT_HIGH;
                  else                      cnt   <= cnt + 1'b1;
               end
               PHY_WAIT_HIGH: begin
                  if (line_s) state <= PHY_IDLE;
               end
               PHY_RESET_LOW: begin
                  if (line_s) begin
                     state <= PHY_PRES_WAIT;
                     cnt   <= '0;
                  end
               end
               PHY_PRES_WAIT: begin
                  if (cnt >= t_pdh - 1'b1) begin
                     state <= PHY_PRES_LOW;
                     cnt   <= '0;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               PHY_PRES_LOW: begin
                  if (cnt >= t_pdl - 1'b1) state <= PHY_IDLE;
                  else                     cnt   <= cnt + 1'b1;
               end
               default: state <= PHY_IDLE;
            endcase
         end
      end
   end

   assign drive_low = (state == PHY_PRES_LOW) || (state == PHY_READ_SLOT && !send_q);

   // R6: an acknowledge needs an offered bit and a slot-start edge
   p_ack_needs_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ack |-> $past(tx_valid));
   p_ack_needs_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ack |-> $past(fall));
   // R4: the received-bit strobe lasts one cycle
   p_rx_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);
   // R2: a recognised reset releases the line on the next edge
   p_reset_releases_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rst_hit |=> !drive_low);
   // R5: the decoded bit is the level seen at the sample point
   p_rx_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> (rx_bit == $past(line_s)));

endmodule

// File: rtl/owire_slave_phy.sv
module owire_slave_phy
   import owire_pkg::*;
#(
   parameter int unsigned CLKS_PER_US = 50,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic overdrive,
   input  logic dq_in,
   output logic dq_pull_low,
   output logic rx_valid,
   output logic rx_bit,
   output logic reset_seen,
   input  logic tx_valid,
   input  logic tx_bit,
   output logic tx_ack
);

   localparam int unsigned RESET_CYC = BUS_RESET_US * CLKS_PER_US;

   generate
      if (OD_SAMPLE_US * CLKS_PER_US <= SYNC_STAGES + 1) begin : g_bad_rate
         $error("owire_slave_phy: CLKS_PER_US too small for the overdrive sample point");
      end
   endgenerate

   logic line_s;
   logic fall;
   logic rst_hit;

   owire_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_raw (dq_in),
      .line_s   (line_s),
      .fall     (fall)
   );

   owire_low_timer #(.LIMIT(RESET_CYC)) u_low (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_s (line_s),
      .hit    (rst_hit)
   );

   owire_slot_fsm #(.CLKS_PER_US(CLKS_PER_US)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .overdrive (overdrive),
      .line_s    (line_s),
      .fall      (fall),
      .rst_hit   (rst_hit),
      .tx_valid  (tx_valid),
      .tx_bit    (tx_bit),
      .drive_low (dq_pull_low),
      .rx_valid  (rx_valid),
      .rx_bit    (rx_bit),
      .tx_ack    (tx_ack)
   );

   assign reset_seen = rst_hit;

   // R7: a write-bit strobe never coincides with the slave pulling the line
   p_rx_not_driving_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> !dq_pull_low);

endmodule

// File: tb/tb_owire_slave_phy.sv
module tb_owire_slave_phy;

   localparam int CPU = 2;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n, overdrive, master_low, tx_valid, tx_bit;
   logic dq, dq_pull_low, rx_valid, rx_bit, reset_seen, tx_ack;

   assign dq = ~(master_low | dq_pull_low);

   owire_slave_phy #(.CLKS_PER_US(CPU)) dut (
      .clk(clk), .rst_n(rst_n), .overdrive(overdrive), .dq_in(dq),
      .dq_pull_low(dq_pull_low), .rx_valid(rx_valid), .rx_bit(rx_bit),
      .reset_seen(reset_seen), .tx_valid(tx_valid), .tx_bit(tx_bit), .tx_ack(tx_ack)
   );

   int n_chk = 0, n_fail = 0, cyc = 0;
   int rx_count = 0, ack_count = 0;

   always @(negedge clk) begin
      if (rx_valid) rx_count++;
      if (tx_ack)   ack_count++;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: run did not finish, actual=%0d expected<=150000", cyc);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic int us(input int x);
      return x * CPU;
   endfunction

   task automatic write_slot(input bit b);
      int s    = overdrive ? us(3) : us(30);
      int slot = overdrive ? 16 : 120;
      int lowl = b ? 2 : slot;
      int acks = ack_count;
      master_low = 1'b1;
      for (int n = 1; n <= slot; n++) begin
         step();
         if (n == s + 3) chk(rx_valid == 1'b0, "R4 rx_valid early", rx_valid, 0);
         if (n == s + 4) begin
            chk(rx_valid == 1'b1, "R4 rx_valid due", rx_valid, 1);
            chk(rx_bit == b, "R5 rx_bit value", rx_bit, b);
         end
         if (n == s + 5) chk(rx_valid == 1'b0, "R4 rx_valid one cycle", rx_valid, 0);
         if (n == lowl) master_low = 1'b0;
      end
      master_low = 1'b0;
      repeat (4) step();
      chk(ack_count == acks, "R8 no tx_ack in write slot", ack_count - acks, 0);
   endtask

   task automatic read_slot(input bit b);
      int h    = overdrive ? us(3) : us(30);
      int slot = overdrive ? 16 : 120;
      int rxs  = rx_count;
      tx_bit     = b;
      tx_valid   = 1'b1;
      master_low = 1'b1;
      for (int n = 1; n <= slot; n++) begin
         step();
         if (n == 2) chk(tx_ack == 1'b0, "R6 tx_ack early", tx_ack, 0);
         if (n == 3) begin
            chk(tx_ack == 1'b1, "R6 tx_ack due", tx_ack, 1);
            chk(dq_pull_low == !b, b ? "R7 no drive for 1" : "R6 drive start", dq_pull_low, !b);
            tx_valid   = 1'b0;
            master_low = 1'b0;
         end
         if (n == 4) chk(tx_ack == 1'b0, "R6 tx_ack one cycle", tx_ack, 0);
         if (n == h) chk(dq == b, b ? "R7 line reads 1" : "R6 line reads 0", dq, b);
         if (n == h + 2) chk(dq_pull_low == !b, b ? "R7 no drive for 1" : "R6 drive held", dq_pull_low, !b);
         if (n == h + 3) chk(dq_pull_low == 1'b0, "R6 drive released", dq_pull_low, 0);
      end
      repeat (4) step();
      chk(rx_count == rxs, "R7 no rx_valid in read slot", rx_count - rxs, 0);
   endtask

   task automatic bus_reset(input bit glitch);
      int r   = us(480);
      int pdh = overdrive ? us(3) : us(30);
      int pdl = overdrive ? us(10) : us(120);
      int rxs, acks;
      master_low = 1'b1;
      for (int n = 1; n <= r + 4; n++) begin
         step();
         if (n == r + 1) chk(reset_seen == 1'b0, "R2 reset_seen early", reset_seen, 0);
         if (n == r + 2) chk(reset_seen == 1'b1, "R2 reset_seen due", reset_seen, 1);
         if (n == r + 3) chk(reset_seen == 1'b0, "R2 reset_seen one cycle", reset_seen, 0);
      end
      rxs  = rx_count;
      acks = ack_count;
      master_low = 1'b0;
      for (int m = 1; m <= pdh + pdl + 8; m++) begin
         step();
         if (glitch && m == 10) master_low = 1'b1;
         if (glitch && m == 12) master_low = 1'b0;
         if (m == pdh + 2) chk(dq_pull_low == 1'b0, "R3 presence early", dq_pull_low, 0);
         if (m == pdh + 3) chk(dq_pull_low == 1'b1, "R3 presence start", dq_pull_low, 1);
         if (m == pdh + pdl + 2) chk(dq_pull_low == 1'b1, "R3 presence held", dq_pull_low, 1);
         if (m == pdh + pdl + 3) chk(dq_pull_low == 1'b0, "R3 presence end", dq_pull_low, 0);
      end
      if (glitch) begin
         chk(rx_count == rxs, "R10 no rx_valid in presence", rx_count - rxs, 0);
         chk(ack_count == acks, "R10 no tx_ack in presence", ack_count - acks, 0);
      end
      repeat (4) step();
   endtask

   initial begin
      rst_n = 1'b0; overdrive = 1'b0; master_low = 1'b0; tx_valid = 1'b0; tx_bit = 1'b0;
      repeat (5) step();
      chk(dq_pull_low == 1'b0 && rx_valid == 1'b0 && reset_seen == 1'b0 && tx_ack == 1'b0,
          "R1 outputs in reset", {dq_pull_low, rx_valid, reset_seen, tx_ack}, 0);
      rst_n = 1'b1;
      step();
      chk(dq_pull_low == 1'b0 && rx_valid == 1'b0 && reset_seen == 1'b0 && tx_ack == 1'b0,
          "R1 outputs after reset", {dq_pull_low, rx_valid, reset_seen, tx_ack}, 0);
      repeat (4) step();

      // standard speed
      bus_reset(1'b1);
      for (int i = 0; i < 8; i++) write_slot(8'hA5 >> i);
      for (int i = 0; i < 8; i++) read_slot(8'h3C >> i);

      // R9: overdrive timing set
      overdrive = 1'b1;
      bus_reset(1'b0);
      for (int i = 0; i < 8; i++) write_slot(8'h5A >> i);
      for (int i = 0; i < 8; i++) read_slot(8'hC3 >> i);

      overdrive = 1'b0;
      bus_reset(1'b0);
      write_slot(1'b0);
      read_slot(1'b0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule